// File: doc/BRIEF.md
# Chainable Serial Converter Register Front End

This block is the digital input stage of a serial-fed digital-to-analog converter meant to be wired in a chain. A 12-bit shift register takes a word from a serial data pin, most significant bit first. On every shift the register's top bit is driven onto a serial output pin, so the word held before is pushed out while the new one comes in. The serial output of one device can therefore feed the serial input of the next. Any number of devices can share one data line, one shift clock and one load line.

Four strobe pins form the shift clock. Three of them are active on a rising edge and one on a falling edge. Holding any strobe at its active level stops all shifting. Two active-low load pins copy the shift register into the 12-bit converter word, but only while both are low. An active-low asynchronous clear empties the converter word and leaves the shift register as it was.

Every input is brought into the system clock domain by a two-flop synchronizer before any edge or level is evaluated.

Top module: `chain_dac_front`

## Requirements
- R1: After reset the converter word is 0, the shift register is 0 and the serial output is 0.
- R2: Serial bits enter bit 0 of the shift register and move toward bit 11. After 12 shifts and a load, the converter word holds the first bit sent in bit 11 and the last bit sent in bit 0.
- R3: The serial output always equals bit 11 of the shift register. It therefore repeats the serial input delayed by exactly 12 shifts, and changes only when a shift happens.
- R4: Each rising-edge strobe, `strobeRise[0]`, `strobeRise[1]` and `strobeRise[2]`, makes one shift when it goes from 0 to 1 while the other strobes are inactive.
- R5: The falling-edge strobe `strobeFall` makes one shift when it goes from 1 to 0 while the other strobes are inactive.
- R6: While any strobe is held at its active level (1 for `strobeRise`, 0 for `strobeFall`), edges on the other strobes cause no shift.
- R7: A strobe event causes exactly one shift, however many clock cycles the strobe stays active.
- R8: The converter word takes the shift register contents only while `loadAN` and `loadBN` are both 0. With only one of them low, the word does not change.
- R9: If a load and a shift fall in the same cycle, the converter word takes the shift register value from before that shift.
- R10: While `clearN` is 0, the converter word is 0 at once, without waiting for a clock edge and whatever the other inputs do.
- R11: A clear does not change the shift register.
- R12: A load request made while `clearN` is 0 has no effect, and the converter word stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| strobeRise | input | 3 | Strobes that shift on a rising edge; a strobe held high blocks shifting |
| strobeFall | input | 1 | Strobe that shifts on a falling edge; held low it blocks shifting |
| serIn | input | 1 | Serial data in, MSB first |
| loadAN | input | 1 | First active-low load request |
| loadBN | input | 1 | Second active-low load request |
| clearN | input | 1 | Active-low asynchronous clear of the converter word |
| serOut | output | 1 | Serial data out, bit 11 of the shift register |
| dacWord | output | 12 | Converter word |

## Verification
The bench sends a set of computed words through the chain and cycles through all four strobes. It checks that the previous word comes out of `serOut` bit by bit, so a reversed bit order, an off-by-one delay or a wrong strobe polarity would show up as a wrong output bit. Strobes are held active for many cycles, and one strobe is parked active while the others are pulsed. A level-triggered shift would then add extra shifts, and a missing hold-off would let the pulsed strobes through; both would shift the loaded word. The bench asserts a load and a shift in the same cycle, which catches a converter word that takes the post-shift value. It asserts only one load pin, which catches a load decoded with OR. Finally it clears the word and loads it again afterwards, which exposes a clear that also wipes the shift register or that waits for a clock edge.

// File: rtl/chain_dac_pkg.sv
package chain_dac_pkg;
  localparam int WORD_W = 12;
  localparam int NUM_RISE = 3;

  typedef struct packed {
    logic shiftEn;
    logic loadEn;
  } ctrl_t;
endpackage

// File: rtl/chain_dac_sync.sv
module chain_dac_sync #(
  parameter int N = 1,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] asyncIn,
  output logic [N-1:0] syncOut
);
  logic [N-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= RST_VAL;
      else if (s == 0) stage[s] <= asyncIn;
      else stage[s] <= stage[(s > 0) ? s - 1 : 0];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/chain_dac_ctrl.sv
module chain_dac_ctrl
  import chain_dac_pkg::*;
#(
  parameter int RISE_N = NUM_RISE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RISE_N-1:0] riseSync,
  input  logic              fallSync,
  input  logic              loadASync,
  input  logic              loadBSync,
  output ctrl_t             ctrl
);
  logic combNow;
  logic combPrev;

  // the shift clock is active while any strobe is at its active level
  assign combNow = (|riseSync) | ~fallSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) combPrev <= 1'b0;
    else combPrev <= combNow;
  end

  always_comb begin
    ctrl.shiftEn = combNow & ~combPrev;
    ctrl.loadEn = ~loadASync & ~loadBSync;
  end

  // R7
  single_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftEn |=> !ctrl.shiftEn);

  // R6
  hold_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(combNow) |-> !ctrl.shiftEn);
endmodule

// File: rtl/chain_dac_datapath.sv
module chain_dac_datapath
  import chain_dac_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clearN,
  input  ctrl_t        ctrl,
  input  logic         serBit,
  output logic         serOut,
  output logic [W-1:0] dacWord
);
  logic [W-1:0] shiftReg;
  logic         wordRstN;

  assign wordRstN = rstN & clearN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (ctrl.shiftEn) shiftReg <= {shiftReg[W-2:0], serBit};
  end

  always_ff @(posedge clk or negedge wordRstN) begin
    if (!wordRstN) dacWord <= '0;
    else if (ctrl.loadEn) dacWord <= shiftReg;
  end

  assign serOut = shiftReg[W-1];

  // R3
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.shiftEn |=> $stable(serOut));

  // R3
  ser_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.shiftEn |=> serOut == $past(shiftReg[W-2]));

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clearN |-> dacWord == '0);

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.loadEn && clearN) |=> (!clearN || $stable(dacWord)));

  // R9
  word_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loadEn && clearN) |=> (!clearN || dacWord == $past(shiftReg)));
endmodule

// File: rtl/chain_dac_front.sv
module chain_dac_front
  import chain_dac_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int RISE_N = NUM_RISE,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RISE_N-1:0] strobeRise,
  input  logic              strobeFall,
  input  logic              serIn,
  input  logic              loadAN,
  input  logic              loadBN,
  input  logic              clearN,
  output logic              serOut,
  output logic [W-1:0]      dacWord
);
  localparam int SYNC_N = RISE_N + 4;
  localparam logic [SYNC_N-1:0] SYNC_RST = {3'b111, 1'b0, {RISE_N{1'b0}}};

  logic [SYNC_N-1:0] rawIn;
  logic [SYNC_N-1:0] syncIn;
  ctrl_t             ctrl;

  assign rawIn = {loadBN, loadAN, strobeFall, serIn, strobeRise};

  chain_dac_sync #(.N(SYNC_N), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(rawIn), .syncOut(syncIn)
  );

  chain_dac_ctrl #(.RISE_N(RISE_N)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .riseSync(syncIn[RISE_N-1:0]),
    .fallSync(syncIn[RISE_N+1]),
    .loadASync(syncIn[RISE_N+2]),
    .loadBSync(syncIn[RISE_N+3]),
    .ctrl(ctrl)
  );

  chain_dac_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .clearN(clearN), .ctrl(ctrl),
    .serBit(syncIn[RISE_N]), .serOut(serOut), .dacWord(dacWord)
  );
endmodule

// File: tb/tb_chain_dac_front.sv
`timescale 1ns/1ps
module tb_chain_dac_front;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  strobeRise = 3'b000;
  logic        strobeFall = 1'b1;
  logic        serIn = 1'b0;
  logic        loadAN = 1'b1;
  logic        loadBN = 1'b1;
  logic        clearN = 1'b1;
  logic        serOut;
  logic [11:0] dacWord;

  int          nRun = 0;
  int          nFail = 0;
  logic [11:0] model = '0;

  always #2.5 clk = ~clk;

  chain_dac_front dut (
    .clk(clk), .rstN(rstN), .strobeRise(strobeRise), .strobeFall(strobeFall),
    .serIn(serIn), .loadAN(loadAN), .loadBN(loadBN), .clearN(clearN),
    .serOut(serOut), .dacWord(dacWord)
  );

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setStrobe(int idx, bit act);
    if (idx < 3) strobeRise[idx] = act;
    else strobeFall = ~act;
  endtask

  task automatic pulse(int idx, bit b, int hold);
    serIn = b;
    repeat (3) @(negedge clk);
    setStrobe(idx, 1'b1);
    repeat (hold) @(negedge clk);
    setStrobe(idx, 1'b0);
    repeat (4) @(negedge clk);
  endtask

  task automatic doLoad(bit a, bit b);
    loadAN = a; loadBN = b;
    repeat (4) @(negedge clk);
    loadAN = 1'b1; loadBN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendWord(logic [11:0] w, int strobeBase);
    for (int i = 11; i >= 0; i--) begin
      check("R3 serOut before shift", {11'd0, serOut}, {11'd0, model[11]});
      pulse((strobeBase + i) % 4, w[i], 3);
      model = {model[10:0], w[i]};
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [11:0] w;
    logic [11:0] saved;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 dacWord", dacWord, 12'h000);
    check("R1 serOut", {11'd0, serOut}, 12'h000);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    doLoad(1'b0, 1'b0);
    check("R1 shift register", dacWord, 12'h000);

    // R2 R3 R4 R5 sweep of computed words across all strobes
    for (int k = 0; k < 20; k++) begin
      w = (k < 12) ? (12'h001 << k) : 12'((k * 12'h2D7) ^ (k << 7));
      sendWord(w, k);
      check("R3 serOut after word", {11'd0, serOut}, {11'd0, w[11]});
      doLoad(1'b0, 1'b0);
      check("R2 loaded word", dacWord, w);
    end
    sendWord(12'hFFF, 3);
    doLoad(1'b0, 1'b0);
    check("R2 all ones", dacWord, 12'hFFF);

    // R8 single load pin has no effect
    saved = dacWord;
    sendWord(12'h5A3, 1);
    doLoad(1'b0, 1'b1);
    check("R8 only loadAN", dacWord, saved);
    doLoad(1'b1, 1'b0);
    check("R8 only loadBN", dacWord, saved);
    doLoad(1'b0, 1'b0);
    check("R8 both low", dacWord, 12'h5A3);

    // R7 one long strobe event gives one shift
    for (int idx = 0; idx < 4; idx++) begin
      pulse(idx, idx[0], 40);
      model = {model[10:0], idx[0]};
      doLoad(1'b0, 1'b0);
      check("R7 long strobe", dacWord, model);
    end

    // R6 a strobe parked active blocks the others
    for (int hold = 0; hold < 4; hold++) begin
      serIn = 1'b1;
      repeat (3) @(negedge clk);
      setStrobe(hold, 1'b1);
      model = {model[10:0], 1'b1};
      repeat (4) @(negedge clk);
      for (int o = 0; o < 4; o++)
        if (o != hold) pulse(o, 1'b0, 3);
      setStrobe(hold, 1'b0);
      repeat (4) @(negedge clk);
      doLoad(1'b0, 1'b0);
      check("R6 hold-off", dacWord, model);
    end

    // R9 load and shift in the same cycle
    saved = model;
    serIn = ~model[0];
    repeat (3) @(negedge clk);
    strobeRise[2] = 1'b1; loadAN = 1'b0; loadBN = 1'b0;
    @(negedge clk);
    loadAN = 1'b1; loadBN = 1'b1;
    repeat (3) @(negedge clk);
    strobeRise[2] = 1'b0;
    repeat (4) @(negedge clk);
    model = {model[10:0], ~saved[0]};
    check("R9 pre-shift value", dacWord, saved);
    doLoad(1'b0, 1'b0);
    check("R9 post-shift value", dacWord, model);

    // R10 asynchronous clear
    @(posedge clk);
    #1 clearN = 1'b0;
    #0.5 check("R10 immediate clear", dacWord, 12'h000);
    // R12 load ignored while clear low
    loadAN = 1'b0; loadBN = 1'b0;
    repeat (5) @(negedge clk);
    check("R12 load during clear", dacWord, 12'h000);
    loadAN = 1'b1; loadBN = 1'b1;
    repeat (4) @(negedge clk);
    clearN = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 stays clear", dacWord, 12'h000);
    check("R11 serOut kept", {11'd0, serOut}, {11'd0, model[11]});
    // R11 shift register survives the clear
    doLoad(1'b0, 1'b0);
    check("R11 shift register kept", dacWord, model);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule